// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds eight token flags that two independent processor ports, left and right, share to guard common resources. It sits in its own address space, apart from any shared memory. A port claims a token by writing a zero to a flag and gives it up by writing a one. Each side keeps its own request latch per flag. The hardware resolves the two latches into a single owner, so the two sides can never both hold the same token.

A request from the side that does not hold the token is not lost. It stays in that side's latch, and ownership passes to it in the same clock edge that the holder releases the token. When both sides request a free token in the same cycle, the left port wins and the right request stays queued.

A read copies the flag onto every bit of the read bus. The value is registered when the port's select and output enable first become active, and it stays frozen for as long as both remain active.

Top module: `sem_unit`

## Requirements
- R1: A synchronous reset sets every request latch on both sides to one. After reset all eight flags are free, and a read of any flag from either side returns all ones.
- R2: A write of datum 0 to a free flag gives the token to the writing side at that write's clock edge. Afterwards the writer reads all zeros from that flag and the other side reads all ones.
- R3: While one side holds a flag, writes from the other side do not change the owner. A zero written by the non-holder is kept in its own latch, and that side keeps reading all ones.
- R4: When the holder writes 1 while the other side's latch holds 0, ownership moves to the other side at that same edge. The new holder then reads all zeros and the old holder reads all ones.
- R5: When the holder writes 1 and no request from the other side is pending, the flag becomes free and both sides read all ones.
- R6: When both sides write 0 to the same free flag in the same cycle, the left side gets the token and the right request stays pending. A later left release hands the token to the right side.
- R7: A non-holder that writes 1 after a failed request withdraws that request. A later release by the holder then leaves the flag free.
- R8: The 3-bit address selects one of eight flags (value i selects flag i). Activity on one flag never changes any other flag. A request that is never released keeps the token held indefinitely.
- R9: A read returns the flag on all DATA_W bits. All zeros means the reading side holds the token. All ones means the token is free or held by the other side.
- R10: The read register loads at the first clock edge at which both select and output enable are high. It loads from the flag state as it was before that edge, and sets the valid output. It then holds its value while both stay high, even if the other side changes the flag.
- R11: After any clock edge at which select or output enable is low, that port's read data is all zeros and its valid output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lft_sel | input | 1 | Left semaphore select, active high |
| lft_wr | input | 1 | Left write strobe, active high |
| lft_oe | input | 1 | Left output enable, active high |
| lft_addr | input | IDX_W (3) | Left flag index |
| lft_wdat | input | 1 | Left write datum (0 request, 1 release) |
| lft_rdat | output | DATA_W (18) | Left registered read data |
| lft_rvld | output | 1 | Left read data valid |
| rgt_sel | input | 1 | Right semaphore select, active high |
| rgt_wr | input | 1 | Right write strobe, active high |
| rgt_oe | input | 1 | Right output enable, active high |
| rgt_addr | input | IDX_W (3) | Right flag index |
| rgt_wdat | input | 1 | Right write datum (0 request, 1 release) |
| rgt_rdat | output | DATA_W (18) | Right registered read data |
| rgt_rvld | output | 1 | Right read data valid |

## Verification
The bench targets the hand-off on release when a request is queued. A design that dropped the queued request would leave the flag free, so the waiting side would read ones instead of zeros. It also drives same-cycle requests from both sides. A tie-break fault shows up either as the right side owning the flag or as both sides reading zeros.

A withdrawn request is checked for whether it still steals the token after release. A held read is checked while the other side releases the token, and a read register that tracks the live flag would change mid-read. Random mixed writes on both ports, with all flags read back, expose any cross-talk between flags.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_LFT  = 2'b01,
        OWN_RGT  = 2'b10
    } owner_e;

    typedef struct packed {
        owner_e own;
    } flag_st_t;

    // Latch value 0 means "requesting"; the left side wins a tie on a free flag.
    function automatic owner_e next_owner(owner_e cur, logic lft_req_n, logic rgt_req_n);
        owner_e nx;
        nx = cur;
        unique case (cur)
            OWN_LFT: begin
                if (lft_req_n) nx = rgt_req_n ? OWN_NONE : OWN_RGT;
            end
            OWN_RGT: begin
                if (rgt_req_n) nx = lft_req_n ? OWN_NONE : OWN_LFT;
            end
            default: begin
                if (!lft_req_n)      nx = OWN_LFT;
                else if (!rgt_req_n) nx = OWN_RGT;
                else                 nx = OWN_NONE;
            end
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/sem_req_bank.sv
module sem_req_bank #(
    parameter int unsigned N_FLAGS = 8,
    parameter int unsigned IDX_W   = $clog2(N_FLAGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               wr,
    input  logic [IDX_W-1:0]   addr,
    input  logic               wdat,
    output logic [N_FLAGS-1:0] req_q,
    output logic [N_FLAGS-1:0] req_d
);

    typedef struct packed {
        logic [N_FLAGS-1:0] req;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel && wr) begin
            st_d.req[addr] = wdat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;
    assign req_d = st_d.req;

endmodule

// File: rtl/sem_arbiter.sv
module sem_arbiter #(
    parameter int unsigned N_FLAGS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_FLAGS-1:0] lft_req_d,
    input  logic [N_FLAGS-1:0] rgt_req_d,
    output logic [N_FLAGS-1:0] lft_hold,
    output logic [N_FLAGS-1:0] rgt_hold
);
    import sem_pkg::*;

    for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
        flag_st_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.own = next_owner(st_q.own, lft_req_d[i], rgt_req_d[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q.own <= OWN_NONE;
            end else begin
                st_q <= st_d;
            end
        end

        assign lft_hold[i] = (st_q.own == OWN_LFT);
        assign rgt_hold[i] = (st_q.own == OWN_RGT);
    end

endmodule

// File: rtl/sem_rd_port.sv
module sem_rd_port #(
    parameter int unsigned N_FLAGS = 8,
    parameter int unsigned IDX_W   = $clog2(N_FLAGS),
    parameter int unsigned DATA_W  = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               oe,
    input  logic [IDX_W-1:0]   addr,
    input  logic [N_FLAGS-1:0] hold,
    output logic [DATA_W-1:0]  rdat,
    output logic               rvld
);

    typedef struct packed {
        logic              act;
        logic              vld;
        logic [DATA_W-1:0] dat;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   act_now;

    assign act_now = sel && oe;

    always_comb begin
        st_d     = st_q;
        st_d.act = act_now;
        if (!act_now) begin
            st_d.vld = 1'b0;
            st_d.dat = '0;
        end else if (!st_q.act) begin
            st_d.vld = 1'b1;
            st_d.dat = {DATA_W{~hold[addr]}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdat = st_q.dat;
    assign rvld = st_q.vld;

endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
    parameter int unsigned N_FLAGS = 8,
    parameter int unsigned DATA_W  = 18,
    parameter int unsigned IDX_W   = $clog2(N_FLAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lft_sel,
    input  logic              lft_wr,
    input  logic              lft_oe,
    input  logic [IDX_W-1:0]  lft_addr,
    input  logic              lft_wdat,
    output logic [DATA_W-1:0] lft_rdat,
    output logic              lft_rvld,
    input  logic              rgt_sel,
    input  logic              rgt_wr,
    input  logic              rgt_oe,
    input  logic [IDX_W-1:0]  rgt_addr,
    input  logic              rgt_wdat,
    output logic [DATA_W-1:0] rgt_rdat,
    output logic              rgt_rvld
);
    localparam int unsigned N_SIDES = 2;

    logic [N_SIDES-1:0]              sel_v, wr_v, oe_v, wd_v, rvld_v;
    logic [N_SIDES-1:0][IDX_W-1:0]   adr_v;
    logic [N_SIDES-1:0][N_FLAGS-1:0] req_q_v, req_d_v, hold_v;
    logic [N_SIDES-1:0][DATA_W-1:0]  rdat_v;

    logic [N_FLAGS-1:0] lft_hold, rgt_hold, lft_req, rgt_req;

    // Side 0 is left, side 1 is right.
    assign sel_v  = {rgt_sel,  lft_sel};
    assign wr_v   = {rgt_wr,   lft_wr};
    assign oe_v   = {rgt_oe,   lft_oe};
    assign wd_v   = {rgt_wdat, lft_wdat};
    assign adr_v  = {rgt_addr, lft_addr};
    assign hold_v = {rgt_hold, lft_hold};

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        sem_req_bank #(
            .N_FLAGS (N_FLAGS),
            .IDX_W   (IDX_W)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .sel   (sel_v[s]),
            .wr    (wr_v[s]),
            .addr  (adr_v[s]),
            .wdat  (wd_v[s]),
            .req_q (req_q_v[s]),
            .req_d (req_d_v[s])
        );

        sem_rd_port #(
            .N_FLAGS (N_FLAGS),
            .IDX_W   (IDX_W),
            .DATA_W  (DATA_W)
        ) u_rd (
            .clk  (clk),
            .rst  (rst),
            .sel  (sel_v[s]),
            .oe   (oe_v[s]),
            .addr (adr_v[s]),
            .hold (hold_v[s]),
            .rdat (rdat_v[s]),
            .rvld (rvld_v[s])
        );
    end

    sem_arbiter #(
        .N_FLAGS (N_FLAGS)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .lft_req_d (req_d_v[0]),
        .rgt_req_d (req_d_v[1]),
        .lft_hold  (lft_hold),
        .rgt_hold  (rgt_hold)
    );

    assign lft_req  = req_q_v[0];
    assign rgt_req  = req_q_v[1];
    assign lft_rdat = rdat_v[0];
    assign rgt_rdat = rdat_v[1];
    assign lft_rvld = rvld_v[0];
    assign rgt_rvld = rvld_v[1];

endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
    parameter int unsigned N_FLAGS = 8,
    parameter int unsigned DATA_W  = 18,
    parameter int unsigned IDX_W   = $clog2(N_FLAGS)
) (
    input logic               clk,
    input logic               rst,
    input logic               lft_sel,
    input logic               lft_wr,
    input logic               lft_oe,
    input logic [IDX_W-1:0]   lft_addr,
    input logic               lft_wdat,
    input logic [DATA_W-1:0]  lft_rdat,
    input logic               lft_rvld,
    input logic               rgt_sel,
    input logic               rgt_wr,
    input logic               rgt_oe,
    input logic [IDX_W-1:0]   rgt_addr,
    input logic               rgt_wdat,
    input logic [DATA_W-1:0]  rgt_rdat,
    input logic               rgt_rvld,
    input logic [N_FLAGS-1:0] lft_hold,
    input logic [N_FLAGS-1:0] rgt_hold,
    input logic [N_FLAGS-1:0] lft_req,
    input logic [N_FLAGS-1:0] rgt_req
);

    logic lw0, rw0, lw1, same;
    assign lw0  = lft_sel && lft_wr && !lft_wdat;
    assign lw1  = lft_sel && lft_wr && lft_wdat;
    assign rw0  = rgt_sel && rgt_wr && !rgt_wdat;
    assign same = (lft_addr == rgt_addr);

    // R1
    a_r1_reset_free: assert property (@(posedge clk)
        rst |=> (lft_hold == '0 && rgt_hold == '0 && lft_req == '1 && rgt_req == '1));

    // R2
    a_r2_claim_lft: assert property (@(posedge clk) disable iff (rst)
        (lw0 && !lft_hold[lft_addr] && !rgt_hold[lft_addr]) |=> lft_hold[$past(lft_addr)]);

    // R2
    a_r2_claim_rgt: assert property (@(posedge clk) disable iff (rst)
        (rw0 && !lft_hold[rgt_addr] && !rgt_hold[rgt_addr] && !(lw0 && same))
        |=> rgt_hold[$past(rgt_addr)]);

    // R3
    a_r3_keep_lft: assert property (@(posedge clk) disable iff (rst)
        (lft_hold[rgt_addr] && rgt_sel && rgt_wr && !(lw1 && same))
        |=> lft_hold[$past(rgt_addr)]);

    // R4
    a_r4_handoff: assert property (@(posedge clk) disable iff (rst)
        (lft_hold[lft_addr] && lw1 && !rgt_req[lft_addr] && !(rgt_sel && rgt_wr && same))
        |=> rgt_hold[$past(lft_addr)]);

    // R6
    a_r6_tie_left: assert property (@(posedge clk) disable iff (rst)
        (lw0 && rw0 && same && !lft_hold[lft_addr] && !rgt_hold[lft_addr])
        |=> (lft_hold[$past(lft_addr)] && !rgt_req[$past(lft_addr)]));

    // R9
    a_r9_spread_lft: assert property (@(posedge clk) disable iff (rst)
        lft_rvld |-> (lft_rdat == '0 || lft_rdat == '1));

    // R9
    a_r9_spread_rgt: assert property (@(posedge clk) disable iff (rst)
        rgt_rvld |-> (rgt_rdat == '0 || rgt_rdat == '1));

    // R10
    a_r10_hold_lft: assert property (@(posedge clk) disable iff (rst)
        (lft_rvld && lft_sel && lft_oe) |=> $stable(lft_rdat));

    // R10
    a_r10_hold_rgt: assert property (@(posedge clk) disable iff (rst)
        (rgt_rvld && rgt_sel && rgt_oe) |=> $stable(rgt_rdat));

    // R11
    a_r11_idle_lft: assert property (@(posedge clk) disable iff (rst)
        !(lft_sel && lft_oe) |=> (lft_rdat == '0 && !lft_rvld));

    // R11
    a_r11_idle_rgt: assert property (@(posedge clk) disable iff (rst)
        !(rgt_sel && rgt_oe) |=> (rgt_rdat == '0 && !rgt_rvld));

endmodule

bind sem_unit sem_unit_chk #(
    .N_FLAGS (N_FLAGS),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lft_sel  (lft_sel),
    .lft_wr   (lft_wr),
    .lft_oe   (lft_oe),
    .lft_addr (lft_addr),
    .lft_wdat (lft_wdat),
    .lft_rdat (lft_rdat),
    .lft_rvld (lft_rvld),
    .rgt_sel  (rgt_sel),
    .rgt_wr   (rgt_wr),
    .rgt_oe   (rgt_oe),
    .rgt_addr (rgt_addr),
    .rgt_wdat (rgt_wdat),
    .rgt_rdat (rgt_rdat),
    .rgt_rvld (rgt_rvld),
    .lft_hold (lft_hold),
    .rgt_hold (rgt_hold),
    .lft_req  (lft_req),
    .rgt_req  (rgt_req)
);

// File: tb/sem_unit_test.sv
`timescale 1ns/1ps
module sem_unit_test;

    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l_sel = 0, l_wr = 0, l_oe = 0, l_wd = 0;
    logic          r_sel = 0, r_wr = 0, r_oe = 0, r_wd = 0;
    logic [2:0]    l_adr = 0, r_adr = 0;
    logic [DW-1:0] l_rd, r_rd;
    logic          l_rv, r_rv;

    int checks = 0;
    int errors = 0;

    // Bench model: latch 1 = idle, 0 = request; owner 0 free, 1 left, 2 right.
    bit m_lq[8];
    bit m_rq[8];
    int m_own[8];

    always #2.5 clk = ~clk;

    sem_unit uut (
        .clk(clk), .rst(rst),
        .lft_sel(l_sel), .lft_wr(l_wr), .lft_oe(l_oe), .lft_addr(l_adr), .lft_wdat(l_wd),
        .lft_rdat(l_rd), .lft_rvld(l_rv),
        .rgt_sel(r_sel), .rgt_wr(r_wr), .rgt_oe(r_oe), .rgt_addr(r_adr), .rgt_wdat(r_wd),
        .rgt_rdat(r_rd), .rgt_rvld(r_rv)
    );

    function automatic void model_apply(bit lw, int la, bit ld, bit rw, int ra, bit rd);
        if (lw) m_lq[la] = ld;
        if (rw) m_rq[ra] = rd;
        for (int i = 0; i < 8; i++) begin
            if (m_own[i] == 1 && m_lq[i]) m_own[i] = 0;
            else if (m_own[i] == 2 && m_rq[i]) m_own[i] = 0;
            if (m_own[i] == 0) begin
                if (!m_lq[i]) m_own[i] = 1;
                else if (!m_rq[i]) m_own[i] = 2;
            end
        end
    endfunction

    function automatic logic [DW-1:0] exp_rd(int side, int idx);
        return (m_own[idx] == side + 1) ? {DW{1'b0}} : {DW{1'b1}};
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(bit lw, int la, bit ld, bit rw, int ra, bit rd);
        @(negedge clk);
        l_sel = lw; l_wr = lw; l_adr = la[2:0]; l_wd = ld;
        r_sel = rw; r_wr = rw; r_adr = ra[2:0]; r_wd = rd;
        @(negedge clk);
        l_sel = 0; l_wr = 0; r_sel = 0; r_wr = 0;
        model_apply(lw, la, ld, rw, ra, rd);
    endtask

    task automatic do_rd(bit le, int la, bit re, int ra, string tag);
        @(negedge clk);
        l_sel = le; l_oe = le; l_adr = la[2:0];
        r_sel = re; r_oe = re; r_adr = ra[2:0];
        @(negedge clk);
        if (le) begin
            check({tag, " left data"}, l_rd, exp_rd(0, la));
            check({tag, " left valid"}, {{(DW-1){1'b0}}, l_rv}, {{(DW-1){1'b0}}, 1'b1});
        end
        if (re) begin
            check({tag, " right data"}, r_rd, exp_rd(1, ra));
            check({tag, " right valid"}, {{(DW-1){1'b0}}, r_rv}, {{(DW-1){1'b0}}, 1'b1});
        end
        l_sel = 0; l_oe = 0; r_sel = 0; r_oe = 0;
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 8; i++) do_rd(1, i, 1, i, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_lq[i] = 1; m_rq[i] = 1; m_own[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 / R11: idle outputs after reset, all flags free
        check("R11 left idle after reset", l_rd, '0);
        check("R11 right idle after reset", r_rd, '0);
        read_all("R1 reset free");

        // R2 claim
        do_wr(1, 3, 0, 0, 0, 1);
        do_rd(1, 3, 1, 3, "R2 claim");
        // R3 queued non-holder request
        do_wr(0, 0, 1, 1, 3, 0);
        do_rd(1, 3, 1, 3, "R3 queued");
        // R4 hand-off on release
        do_wr(1, 3, 1, 0, 0, 1);
        check("R4 model owner right", m_own[3] == 2 ? '1 : '0, '1);
        do_rd(1, 3, 1, 3, "R4 handoff");
        // R5 release with nothing pending
        do_wr(0, 0, 1, 1, 3, 1);
        do_rd(1, 3, 1, 3, "R5 free");

        // R6 tie on a free flag
        do_wr(1, 5, 0, 1, 5, 0);
        do_rd(1, 5, 1, 5, "R6 tie left wins");
        do_wr(1, 5, 1, 0, 0, 1);
        do_rd(1, 5, 1, 5, "R6 pending right takes");
        do_wr(0, 0, 1, 1, 5, 1);

        // R7 withdraw a failed request
        do_wr(1, 1, 0, 0, 0, 1);
        do_wr(0, 0, 1, 1, 1, 0);
        do_wr(0, 0, 1, 1, 1, 1);
        do_wr(1, 1, 1, 0, 0, 1);
        do_rd(1, 1, 1, 1, "R7 withdrawn");

        // R8 independence of flags and a held token staying held
        do_wr(1, 0, 0, 1, 7, 0);
        repeat (20) @(negedge clk);
        do_wr(0, 0, 1, 1, 0, 0);
        read_all("R8 independent flags");
        do_wr(1, 0, 1, 1, 7, 1);
        do_wr(0, 0, 1, 1, 0, 1);
        read_all("R8 all released");

        // R9 / R10: held read frozen while the other side releases
        do_wr(0, 0, 1, 1, 4, 0);
        do_wr(1, 4, 0, 0, 0, 1);
        @(negedge clk);
        l_sel = 1; l_oe = 1; l_adr = 3'd4;
        @(negedge clk);
        check("R10 capture before handoff", l_rd, '1);
        check("R10 valid set", {{(DW-1){1'b0}}, l_rv}, {{(DW-1){1'b0}}, 1'b1});
        r_sel = 1; r_wr = 1; r_adr = 3'd4; r_wd = 1;
        @(negedge clk);
        r_sel = 0; r_wr = 0;
        model_apply(0, 0, 1, 1, 4, 1);
        @(negedge clk);
        check("R10 frozen during read", l_rd, '1);
        l_sel = 0; l_oe = 0;
        @(negedge clk);
        check("R11 cleared after read", l_rd, '0);
        check("R11 valid cleared", {{(DW-1){1'b0}}, l_rv}, '0);
        do_rd(1, 4, 1, 4, "R9 new owner reads zeros");
        // R11 select without output enable
        @(negedge clk);
        r_sel = 1; r_oe = 0; r_adr = 3'd4;
        @(negedge clk);
        check("R11 no oe right data", r_rd, '0);
        r_sel = 0;
        do_wr(1, 4, 1, 0, 0, 1);

        // Random mixed traffic
        for (int n = 0; n < 400; n++) begin
            do_wr(bit'($urandom % 2), int'($urandom % 8), bit'($urandom % 2),
                  bit'($urandom % 2), int'($urandom % 8), bit'($urandom % 2));
            if (n % 16 == 15) read_all("R3 random traffic");
        end
        read_all("R4 random final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule